// File: doc/BRIEF.md
# Programmable Road Pattern Lookup

This block turns a stream of per-crossing wire hits from a six-layer chamber into road candidates. Each incoming hit bit starts a short, retriggerable one-shot, so that a wire stays "held" for a programmable number of crossings, long enough to cover the full drift time. Hits that arrive on different layers during neighbouring crossings therefore combine into one image.

For every key wire, the block takes a small window of held wires from each of the five outer layers, and the key wire itself in the middle layer. These bits form an address into a downloadable table, and the entry found there is the pattern ID for that key wire: zero means no road. Because the table holds any contents, one piece of hardware serves different chamber geometries. The same table can also accept roads with six, five or four layers present. All key wires are looked up in parallel, so several roads can be reported in the same crossing. A host loads the table through a simple write port while lookup is switched off. A readout port returns the raw hit image latched at the last crossing, without the stretching. Choosing among the reported roads is left to a later stage.

Top module: `road_pattern_lookup`

## Requirements
- R1: After synchronous reset, every pat_valid bit is 0, every pat_id field is 0, rd_data is 0 and no wire is held.
- R2: A hit on a wire at crossing edge E0 keeps that wire held for N = hold_sel + 1 crossings (hold_sel 0..3 gives 1..4). The held image is visible to the lookup at edges E1 through EN.
- R3: A new hit on a wire that is already held restarts its full hold time. Hits on different layers in neighbouring crossings combine in the held image.
- R4: The lookup address for key wire k has 11 bits with the default span of 2. Side layers 0, 1, 2, 4 and 5 take slots 0..4 in that order. Slot s covers bits 2s and 2s+1, which carry wires k and k+1 of that layer. Bit 10 carries wire k of key layer 3.
- R5: A window wire past the last wire of the chamber reads as 0 in the address.
- R6: With lookup_en high, pat_id for key wire k (field bits [7k+6:7k]) equals the table entry at that wire's address, registered one cycle after the held image. pat_valid[k] is 1 exactly when that entry is nonzero.
- R7: The table returns whatever was loaded at any address, including addresses with only four or five layers present.
- R8: Every key wire is looked up independently in the same cycle, so several wires can report valid roads at once.
- R9: While lookup_en is low, all pat_valid and pat_id outputs are 0 from the next cycle on.
- R10: A table write (tbl_we with tbl_addr and tbl_wdata) takes effect only while lookup_en is low. A write attempted while lookup_en is high leaves the table unchanged.
- R11: rd_data gives layer rd_layer of the hit_in image sampled at the last clock edge, without hold stretching. It reads 0 for rd_layer 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_en | input | 1 | Enables lookup; blocks table writes when high |
| hold_sel | input | 2 | Hold time select, crossings = hold_sel + 1 |
| hit_in | input | 48 | Hits for this crossing; bit l*8+w is layer l, wire w |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 11 | Table write address |
| tbl_wdata | input | 7 | Table write data (pattern ID, 0 = none) |
| rd_layer | input | 3 | Layer selected for raw readout |
| rd_data | output | 8 | Raw latched hits of the selected layer |
| pat_valid | output | 8 | Per key wire: nonzero pattern found |
| pat_id | output | 56 | Per key wire 7-bit pattern ID, wire k at bits [7k+6:7k] |

## Verification
The assertions check four things on every cycle. A hit always produces a held wire on the next edge. No wire stays held longer than four crossings after its last hit. The outputs stay quiet the cycle after lookup is switched off. The raw readout always matches the previous crossing's input. The bench scenarios are needed to show things the assertions cannot: the exact address bit layout, edge-of-chamber zeroing, the 4/5/6-layer acceptance, the exact hold length for each setting, and that a write during lookup really leaves the table untouched.

// File: rtl/road_lut_pkg.sv
package road_lut_pkg;

    localparam int LAYERS    = 6;
    localparam int KEY_LAYER = 3;
    localparam int ID_W      = 7;
    localparam int HSEL_W    = 2;
    localparam int HCNT_W    = HSEL_W + 1;

    typedef logic [ID_W-1:0] pat_id_t;

    typedef enum logic [HSEL_W-1:0] {
        HOLD_ONE   = 2'd0,
        HOLD_TWO   = 2'd1,
        HOLD_THREE = 2'd2,
        HOLD_FOUR  = 2'd3
    } hold_len_e;

    typedef struct packed {
        logic    valid;
        pat_id_t id;
    } road_res_t;

    // number of crossings a wire stays held after a hit
    function automatic logic [HCNT_W-1:0] hold_load(hold_len_e h);
        return {1'b0, h} + HCNT_W'(1);
    endfunction

    // physical layer that feeds address slot s (key layer skipped)
    function automatic int side_layer(int s);
        return (s < KEY_LAYER) ? s : s + 1;
    endfunction

endpackage

// File: rtl/rpl_hit_hold.sv
module rpl_hit_hold
    import road_lut_pkg::*;
#(
    parameter int NBITS = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  hold_len_e        hold_len,
    input  logic [NBITS-1:0] hit,
    output logic [NBITS-1:0] held
);

    logic [HCNT_W-1:0] load_val;
    assign load_val = hold_load(hold_len);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic [HCNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit[i]) begin
                cnt_q <= load_val;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - HCNT_W'(1);
            end
        end

        assign held[i] = (cnt_q != '0);
    end

endmodule

// File: rtl/rpl_road_addr.sv
module rpl_road_addr
    import road_lut_pkg::*;
#(
    parameter int NUM_WIRES = 8,
    parameter int SPAN      = 2,
    parameter int OFFSET    = 0,
    localparam int ADDR_W   = (LAYERS - 1) * SPAN + 1
) (
    input  logic [LAYERS*NUM_WIRES-1:0] held,
    output logic [NUM_WIRES*ADDR_W-1:0] addr
);

    for (genvar k = 0; k < NUM_WIRES; k++) begin : g_key
        for (genvar s = 0; s < LAYERS - 1; s++) begin : g_slot
            localparam int LYR = side_layer(s);
            for (genvar j = 0; j < SPAN; j++) begin : g_win
                localparam int WIRE = k + j - OFFSET;
                if (WIRE >= 0 && WIRE < NUM_WIRES) begin : g_in
                    assign addr[k*ADDR_W + s*SPAN + j] = held[LYR*NUM_WIRES + WIRE];
                end else begin : g_out
                    assign addr[k*ADDR_W + s*SPAN + j] = 1'b0;
                end
            end
        end
        assign addr[k*ADDR_W + ADDR_W - 1] = held[KEY_LAYER*NUM_WIRES + k];
    end

endmodule

// File: rtl/rpl_table.sv
module rpl_table
    import road_lut_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int NUM_PORTS = 8,
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  pat_id_t                       wr_data,
    input  logic [NUM_PORTS*ADDR_W-1:0]   rd_addr,
    output logic [NUM_PORTS*ID_W-1:0]     rd_data
);

    pat_id_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign rd_data[p*ID_W +: ID_W] = mem[rd_addr[p*ADDR_W +: ADDR_W]];
    end

endmodule

// File: rtl/road_pattern_lookup.sv
module road_pattern_lookup
    import road_lut_pkg::*;
#(
    parameter int NUM_WIRES = 8,
    parameter int SPAN      = 2,
    parameter int OFFSET    = 0,
    localparam int ADDR_W   = (LAYERS - 1) * SPAN + 1,
    localparam int IMG_W    = LAYERS * NUM_WIRES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lookup_en,
    input  logic [HSEL_W-1:0]         hold_sel,
    input  logic [IMG_W-1:0]          hit_in,
    input  logic                      tbl_we,
    input  logic [ADDR_W-1:0]         tbl_addr,
    input  logic [ID_W-1:0]           tbl_wdata,
    input  logic [2:0]                rd_layer,
    output logic [NUM_WIRES-1:0]      rd_data,
    output logic [NUM_WIRES-1:0]      pat_valid,
    output logic [NUM_WIRES*ID_W-1:0] pat_id
);

    logic [IMG_W-1:0]            raw_q;
    logic [IMG_W-1:0]            held_q;
    logic [NUM_WIRES*ADDR_W-1:0] key_addr;
    logic [NUM_WIRES*ID_W-1:0]   key_id;
    logic                        wr_ok;
    road_res_t                   res_q [NUM_WIRES];

    // raw crossing latch for readout
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= hit_in;
    end

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (rd_layer == 3'(l)) rd_data = raw_q[l*NUM_WIRES +: NUM_WIRES];
        end
    end

    rpl_hit_hold #(.NBITS(IMG_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .hold_len (hold_len_e'(hold_sel)),
        .hit      (hit_in),
        .held     (held_q)
    );

    rpl_road_addr #(.NUM_WIRES(NUM_WIRES), .SPAN(SPAN), .OFFSET(OFFSET)) u_addr (
        .held (held_q),
        .addr (key_addr)
    );

    assign wr_ok = tbl_we && !lookup_en;

    rpl_table #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_WIRES)) u_table (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_addr (key_addr),
        .rd_data (key_id)
    );

    for (genvar k = 0; k < NUM_WIRES; k++) begin : g_out
        pat_id_t id_now;
        assign id_now = key_id[k*ID_W +: ID_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[k] <= '0;
            end else if (lookup_en) begin
                res_q[k].valid <= (id_now != '0);
                res_q[k].id    <= id_now;
            end else begin
                res_q[k] <= '0;
            end
        end

        assign pat_valid[k]             = res_q[k].valid;
        assign pat_id[k*ID_W +: ID_W]   = res_q[k].id;
    end

endmodule

// File: rtl/road_pattern_lookup_chk.sv
module road_pattern_lookup_chk
    import road_lut_pkg::*;
#(
    parameter int NUM_WIRES = 8,
    localparam int IMG_W    = LAYERS * NUM_WIRES
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lookup_en,
    input logic [IMG_W-1:0]     hit_in,
    input logic [IMG_W-1:0]     held,
    input logic [2:0]           rd_layer,
    input logic [NUM_WIRES-1:0] rd_data,
    input logic [NUM_WIRES-1:0] pat_valid
);

    logic [IMG_W-1:0]     hit_prev;
    logic                 prev_ok;
    logic [NUM_WIRES-1:0] exp_rd;

    always_ff @(posedge clk) begin
        hit_prev <= hit_in;
        prev_ok  <= !rst;
    end

    always_comb begin
        exp_rd = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (rd_layer == 3'(l)) exp_rd = hit_prev[l*NUM_WIRES +: NUM_WIRES];
        end
    end

    // R2: a hit is held on the following cycle
    p_hit_held_r2: assert property (@(posedge clk) disable iff (rst)
        (hit_in != '0) |=> ((held & $past(hit_in)) == $past(hit_in)));

    // R2: no wire stays held beyond four crossings after its last hit
    p_hold_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        (held & ~($past(hit_in, 1) | $past(hit_in, 2) |
                  $past(hit_in, 3) | $past(hit_in, 4))) == '0);

    // R9: outputs are quiet after lookup is switched off
    p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !lookup_en |=> (pat_valid == '0));

    // R11: readout shows the previous crossing's raw hits
    p_raw_readout_r11: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> (rd_data == exp_rd));

endmodule

bind road_pattern_lookup road_pattern_lookup_chk #(.NUM_WIRES(NUM_WIRES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lookup_en (lookup_en),
    .hit_in    (hit_in),
    .held      (held_q),
    .rd_layer  (rd_layer),
    .rd_data   (rd_data),
    .pat_valid (pat_valid)
);

// File: tb/test_road_pattern_lookup.sv
module test_road_pattern_lookup;

    localparam int NW     = 8;
    localparam int NL     = 6;
    localparam int ADDR_W = 11;
    localparam int IW     = 7;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lookup_en = 1'b0;
    logic [1:0]        hold_sel = 2'd0;
    logic [NL*NW-1:0]  hit_in = '0;
    logic              tbl_we = 1'b0;
    logic [ADDR_W-1:0] tbl_addr = '0;
    logic [IW-1:0]     tbl_wdata = '0;
    logic [2:0]        rd_layer = 3'd0;
    logic [NW-1:0]     rd_data;
    logic [NW-1:0]     pat_valid;
    logic [NW*IW-1:0]  pat_id;

    int tests = 0;
    int fails = 0;
    logic [IW-1:0] mdl [DEPTH];

    always #5 clk = ~clk;

    road_pattern_lookup i_road_pattern_lookup (
        .clk(clk), .rst(rst), .lookup_en(lookup_en), .hold_sel(hold_sel),
        .hit_in(hit_in), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .rd_layer(rd_layer), .rd_data(rd_data),
        .pat_valid(pat_valid), .pat_id(pat_id)
    );

    // image with wire w set in each layer whose bit is set in lmask
    function automatic logic [NL*NW-1:0] road(int w, logic [5:0] lmask);
        logic [NL*NW-1:0] img = '0;
        for (int l = 0; l < NL; l++) if (lmask[l]) img[l*NW + w] = 1'b1;
        return img;
    endfunction

    // address layout from R4/R5
    function automatic logic [ADDR_W-1:0] addr_of(logic [NL*NW-1:0] img, int k);
        logic [ADDR_W-1:0] a = '0;
        int lmap [5] = '{0, 1, 2, 4, 5};
        for (int s = 0; s < 5; s++)
            for (int j = 0; j < 2; j++)
                if (k + j < NW) a[s*2 + j] = img[lmap[s]*NW + k + j];
        a[10] = img[3*NW + k];
        return a;
    endfunction

    task automatic check_out(logic [NL*NW-1:0] img, string req);
        logic [NW-1:0]    ev = '0;
        logic [NW*IW-1:0] ei = '0;
        for (int k = 0; k < NW; k++) begin
            logic [IW-1:0] e = lookup_en ? mdl[addr_of(img, k)] : '0;
            ei[k*IW +: IW] = e;
            ev[k] = (e != '0);
        end
        tests++;
        if (pat_valid !== ev || pat_id !== ei) begin
            fails++;
            $display("FAIL %s: valid=%h id=%h expected valid=%h id=%h", req, pat_valid, pat_id, ev, ei);
        end
    endtask

    task automatic tbl_write(logic [ADDR_W-1:0] a, logic [IW-1:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        if (!lookup_en) mdl[a] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // drive one crossing of hits; returns at the negedge after E0
    task automatic pulse(logic [NL*NW-1:0] img);
        @(negedge clk);
        hit_in = img;
        @(negedge clk);
        hit_in = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        tests++;
        if (pat_valid !== '0 || pat_id !== '0 || rd_data !== '0) begin
            fails++;
            $display("FAIL R1: valid=%h id=%h rd=%h expected all 0", pat_valid, pat_id, rd_data);
        end
    endtask

    task automatic t_load;
        lookup_en = 1'b0;
        for (int a = 0; a < DEPTH; a++) tbl_write(ADDR_W'(a), '0);
        tbl_write(11'h555, 7'd10);  // R4: six layers, key wire
        tbl_write(11'h505, 7'd20);  // R7: layers 0,1,3,5
        tbl_write(11'h545, 7'd30);  // R7: layers 0,1,3,4,5
        tbl_write(11'h7FF, 7'd99);
        lookup_en = 1'b1;
    endtask

    task automatic t_straight;
        hold_sel = 2'd0;
        pulse(road(3, 6'b111111));
        @(negedge clk);
        check_out(road(3, 6'b111111), "R4/R6 six-layer road");
        @(negedge clk);
        check_out('0, "R2 hold of one crossing ended");
        idle(2);
    endtask

    task automatic t_partial;
        hold_sel = 2'd0;
        pulse(road(3, 6'b101011));
        @(negedge clk);
        check_out(road(3, 6'b101011), "R7 four of six");
        idle(2);
        pulse(road(3, 6'b111011));
        @(negedge clk);
        check_out(road(3, 6'b111011), "R7 five of six");
        idle(2);
    endtask

    task automatic t_hold_len;
        hold_sel = 2'd2;
        pulse(road(3, 6'b111111));
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check_out(road(3, 6'b111111), "R2 held for three crossings");
        end
        @(negedge clk);
        check_out('0, "R2 released after three crossings");
        idle(2);
    endtask

    task automatic t_retrigger;
        hold_sel = 2'd1;
        @(negedge clk); hit_in = road(3, 6'b111111);
        @(negedge clk); hit_in = road(3, 6'b111111);
        @(negedge clk); hit_in = '0;
        @(negedge clk);
        check_out(road(3, 6'b111111), "R3 held after retrigger");
        @(negedge clk);
        check_out(road(3, 6'b111111), "R3 hold restarted");
        @(negedge clk);
        check_out('0, "R3 released after retrigger");
        idle(2);
    endtask

    task automatic t_accumulate;
        hold_sel = 2'd3;
        @(negedge clk); hit_in = road(3, 6'b000111);
        @(negedge clk); hit_in = road(3, 6'b111000);
        @(negedge clk); hit_in = '0;
        check_out(road(3, 6'b000111), "R3 partial image first");
        @(negedge clk);
        check_out(road(3, 6'b111111), "R3 layers combined across crossings");
        idle(6);
    endtask

    task automatic t_multi;
        hold_sel = 2'd0;
        pulse(road(1, 6'b111111) | road(6, 6'b111111));
        @(negedge clk);
        check_out(road(1, 6'b111111) | road(6, 6'b111111), "R8 two roads at once");
        tests++;
        if (pat_valid !== 8'b0100_0010) begin
            fails++;
            $display("FAIL R8: valid=%h expected 42", pat_valid);
        end
        idle(2);
    endtask

    task automatic t_edge;
        hold_sel = 2'd0;
        pulse('1);
        @(negedge clk);
        check_out('1, "R5 edge wire window");
        tests++;
        if (pat_id[7*IW +: IW] !== 7'd10 || pat_id[0 +: IW] !== 7'd99) begin
            fails++;
            $display("FAIL R5: key7=%0d key0=%0d expected 10 99", pat_id[7*IW +: IW], pat_id[0 +: IW]);
        end
        idle(2);
    endtask

    task automatic t_disabled;
        hold_sel = 2'd0;
        @(negedge clk); lookup_en = 1'b0;
        pulse(road(3, 6'b111111));
        @(negedge clk);
        check_out(road(3, 6'b111111), "R9 disabled outputs zero");
        lookup_en = 1'b1;
        idle(2);
    endtask

    task automatic t_write_blocked;
        hold_sel = 2'd0;
        lookup_en = 1'b1;
        tbl_write(11'h555, 7'd50);
        pulse(road(3, 6'b111111));
        @(negedge clk);
        tests++;
        if (pat_id[3*IW +: IW] !== 7'd10) begin
            fails++;
            $display("FAIL R10: id=%0d expected 10", pat_id[3*IW +: IW]);
        end
        idle(2);
    endtask

    task automatic t_readout;
        logic [NL*NW-1:0] img = '0;
        hold_sel = 2'd3;
        img[2*NW +: NW] = 8'hA5;
        img[4*NW +: NW] = 8'h3C;
        @(negedge clk); hit_in = img; rd_layer = 3'd2;
        @(negedge clk); hit_in = '0;
        #1;
        tests++;
        if (rd_data !== 8'hA5) begin fails++; $display("FAIL R11: rd=%h expected a5", rd_data); end
        rd_layer = 3'd4; #1;
        tests++;
        if (rd_data !== 8'h3C) begin fails++; $display("FAIL R11: rd=%h expected 3c", rd_data); end
        rd_layer = 3'd7; #1;
        tests++;
        if (rd_data !== 8'h00) begin fails++; $display("FAIL R11: rd=%h expected 00 for layer 7", rd_data); end
        rd_layer = 3'd4;
        @(negedge clk);
        tests++;
        if (rd_data !== 8'h00) begin fails++; $display("FAIL R11: rd=%h expected 00, raw not stretched", rd_data); end
        idle(6);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < DEPTH; a++) mdl[a] = '0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        t_reset;
        t_load;
        t_straight;
        t_partial;
        t_hold_len;
        t_retrigger;
        t_accumulate;
        t_multi;
        t_edge;
        t_disabled;
        t_write_blocked;
        t_readout;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule